// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block lets one processor signal another through a bank of software-triggered interrupt sources. Each source has a pending flag and a mask flag. A writer raises a source by writing a one to its bit at the trigger address. The receiving processor sees a single interrupt line that is high whenever an unmasked source is pending. It reads the raw or masked status to find out which sources fired, then retires them with a write-one-to-clear at either the status-clear or the acknowledge address.

Mask bits are 1 for disabled and 0 for enabled. They are never written directly. The set alias turns written ones into mask ones, and the clear alias turns written ones into mask zeros. Dedicated hardware event pulses can also raise sources, gated per bit by a parameter. When a raise and a clear hit the same bit in the same cycle, the raise wins.

The register port is a 3-bit word index with a separate write index and read index. Reads are combinational and have no side effects.

Top module: `ipi_ctrl`

## Requirements
- R1: After a synchronous reset, every pending bit is 0, every mask bit is 1, and `irq` is low.
- R2: A write to index 1 (mask set) sets each mask bit whose written bit is 1. Written zeros leave those mask bits unchanged.
- R3: A write to index 2 (mask clear) clears each mask bit whose written bit is 1. Written zeros leave those mask bits unchanged.
- R4: A write to index 3 (status clear) clears each pending bit whose written bit is 1. Written zeros leave those pending bits unchanged.
- R5: A write to index 4 (acknowledge) clears pending bits with the same write-one-to-clear rule as index 3.
- R6: A write to index 5 (trigger) sets each pending bit whose written bit is 1. Reading index 5 always returns 0.
- R7: A 1 on bit i of `hw_evt` during a clock edge sets pending bit i, provided the bit is enabled in the event-enable parameter (all bits are enabled by default).
- R8: When a trigger bit or an event bit arrives in the same cycle as a status-clear or acknowledge write to that bit, the bit is pending afterwards.
- R9: Reading index 7 returns the pending vector whatever the mask. Reading index 6 returns pending AND NOT mask. Reading index 0 returns the mask. Reading indices 1 to 5 returns 0. No read changes any state.
- R10: `irq` is a register that takes the OR of the masked status at each clock edge, so it lags the pending and mask state by one cycle.
- R11: Setting the mask bit of a pending source hides that source from the masked status and from `irq` but does not clear it. Clearing the mask bit again makes the source visible.
- R12: Writes to indices 0, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Register index of the write |
| wr_data | input | NSRC | Write data, one bit per source |
| rd_addr | input | 3 | Register index of the read |
| rd_data | output | NSRC | Combinational read data |
| hw_evt | input | NSRC | Per-source hardware event pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
A directed sequence walks each alias with three kinds of data: single bits, multi-bit patterns and all-zero data. Single bits show that only the addressed bit moves. Multi-bit patterns show that the bits do not disturb one another. All-zero data and writes to the read-only indices show that nothing moves when nothing should. Collision cycles put an event or trigger bit on top of a status-clear or acknowledge of the same bit, which tells "raise wins" apart from "clear wins". A long run of random writes, events and read indices is then checked every cycle against a behavioural model. It compares `irq` and the read data, and so catches any one-cycle slip in the output register and any mix-up between the raw, masked and mask views.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int IDX_W = 3;

    // Register indices; decoders on both sides depend on these values.
    typedef enum logic [IDX_W-1:0] {
        IDX_MASK      = 3'd0,
        IDX_MASK_SET  = 3'd1,
        IDX_MASK_CLR  = 3'd2,
        IDX_PEND_CLR  = 3'd3,
        IDX_ACK       = 3'd4,
        IDX_TRIG      = 3'd5,
        IDX_MASKED    = 3'd6,
        IDX_RAW       = 3'd7
    } ipi_idx_e;

    // One strobe per write-side action.
    typedef struct packed {
        logic mask_set;
        logic mask_clr;
        logic pend_clr;
        logic ack;
        logic trig;
    } ipi_wstrb_t;

    function automatic logic idx_is_readable(input logic [IDX_W-1:0] idx);
        return (idx == IDX_MASK) || (idx == IDX_MASKED) || (idx == IDX_RAW);
    endfunction

endpackage

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
    import ipi_pkg::*;
(
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    output ipi_wstrb_t       strb
);
    always_comb begin
        strb = '0;
        if (wr_en) begin
            case (ipi_idx_e'(wr_addr))
                IDX_MASK_SET: strb.mask_set = 1'b1;
                IDX_MASK_CLR: strb.mask_clr = 1'b1;
                IDX_PEND_CLR: strb.pend_clr = 1'b1;
                IDX_ACK:      strb.ack      = 1'b1;
                IDX_TRIG:     strb.trig     = 1'b1;
                default:      strb          = '0;
            endcase
        end
    end
endmodule

// File: rtl/ipi_mask_reg.sv
module ipi_mask_reg #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_bits,
    input  logic [NSRC-1:0] clr_bits,
    output logic [NSRC-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) mask_q <= '1;
        else     mask_q <= (mask_q | set_bits) & ~clr_bits;
    end

    // R1: reset leaves every source disabled
    p_mask_reset_r1: assert property (@(posedge clk)
        rst |=> (mask_q == '1));

    // R2 / R3: only bits written with a 1 may move
    p_mask_only_written_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((mask_q ^ $past(mask_q)) & ~$past(set_bits | clr_bits)) == '0));

    // R3: a clear-alias one leaves the mask bit at 0
    p_mask_clr_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((mask_q & $past(clr_bits)) == '0));
endmodule

// File: rtl/ipi_pend_reg.sv
module ipi_pend_reg #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] raise_bits,
    input  logic [NSRC-1:0] drop_bits,
    output logic [NSRC-1:0] pend_q
);
    // A raise in the same cycle as a drop survives.
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~drop_bits) | raise_bits;
    end

    // R1: nothing pending after reset
    p_pend_reset_r1: assert property (@(posedge clk)
        rst |=> (pend_q == '0));

    // R8: every raised bit is pending next cycle, cleared or not
    p_raise_kept_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(raise_bits)) == $past(raise_bits)));

    // R4 / R5: dropped bits with no raise are gone
    p_drop_clears_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(drop_bits & ~raise_bits)) == '0));

    // R11: a pending bit only leaves through a drop
    p_no_silent_loss_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((~pend_q) & $past(pend_q & ~drop_bits)) == '0));
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
    import ipi_pkg::*;
#(
    parameter int              NSRC   = 32,
    parameter logic [NSRC-1:0] EVT_EN = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [NSRC-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [NSRC-1:0]  rd_data,
    input  logic [NSRC-1:0]  hw_evt,
    output logic             irq
);
    ipi_wstrb_t      strb;
    logic [NSRC-1:0] set_bits, clr_bits, raise_bits, drop_bits;
    logic [NSRC-1:0] mask_q, pend_q, masked;

    ipi_wr_decode u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .strb   (strb)
    );

    assign set_bits   = strb.mask_set ? wr_data : '0;
    assign clr_bits   = strb.mask_clr ? wr_data : '0;
    assign drop_bits  = (strb.pend_clr || strb.ack) ? wr_data : '0;
    assign raise_bits = (strb.trig ? wr_data : '0) | (hw_evt & EVT_EN);

    ipi_mask_reg #(.NSRC(NSRC)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .set_bits(set_bits),
        .clr_bits(clr_bits),
        .mask_q  (mask_q)
    );

    ipi_pend_reg #(.NSRC(NSRC)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .raise_bits(raise_bits),
        .drop_bits (drop_bits),
        .pend_q    (pend_q)
    );

    assign masked = pend_q & ~mask_q;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |masked;
    end

    always_comb begin
        rd_data = '0;
        if (idx_is_readable(rd_addr)) begin
            case (ipi_idx_e'(rd_addr))
                IDX_MASK:   rd_data = mask_q;
                IDX_MASKED: rd_data = masked;
                IDX_RAW:    rd_data = pend_q;
                default:    rd_data = '0;
            endcase
        end
    end

    // R10: output follows the pending/mask state one cycle later
    p_irq_lag_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == |$past(pend_q & ~mask_q)));

    // R1: output low right after reset
    p_irq_reset_r1: assert property (@(posedge clk)
        rst |=> !irq);

    // R12: writes to read-only indices move neither register
    p_ro_write_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx_is_readable(wr_addr) && hw_evt == '0) |=>
            ($stable(mask_q) && $stable(pend_q)));
endmodule

// File: tb/ipi_ctrl_bench.sv
module ipi_ctrl_bench;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic [N-1:0] hw_evt = '0;
    logic         irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [N-1:0] pend_m = '0;
    logic [N-1:0] mask_m = '1;
    logic         irq_m  = 1'b0;

    ipi_ctrl #(.NSRC(N)) u_ipi_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hw_evt(hw_evt), .irq(irq)
    );

    always #2ns clk = ~clk;

    function automatic logic [N-1:0] expect_read(input logic [2:0] ra);
        case (ra)
            3'd0:    return mask_m;
            3'd6:    return pend_m & ~mask_m;
            3'd7:    return pend_m;
            default: return '0;
        endcase
    endfunction

    // Drive one cycle, check the current state, then advance the model.
    task automatic step(input logic we, input logic [2:0] wa, input logic [N-1:0] wd,
                        input logic [N-1:0] ev, input logic [2:0] ra, input string tag);
        logic [N-1:0] exp_rd;
        logic [N-1:0] drop, raise, setm, clrm;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; hw_evt = ev; rd_addr = ra;
        #1ns;
        exp_rd = expect_read(ra);
        checks++;
        if (rd_data !== exp_rd) begin
            failures++;
            $display("FAIL %s read idx %0d actual=%h expected=%h", tag, ra, rd_data, exp_rd);
        end
        checks++;
        if (irq !== irq_m) begin
            failures++;
            $display("FAIL %s/R10 irq actual=%b expected=%b", tag, irq, irq_m);
        end
        drop  = (we && (wa == 3'd3 || wa == 3'd4)) ? wd : '0;
        raise = ((we && wa == 3'd5) ? wd : '0) | ev;
        setm  = (we && wa == 3'd1) ? wd : '0;
        clrm  = (we && wa == 3'd2) ? wd : '0;
        irq_m  = |(pend_m & ~mask_m);
        pend_m = (pend_m & ~drop) | raise;
        mask_m = (mask_m | setm) & ~clrm;
    endtask

    initial begin
        #400us;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        step(0, 0, '0, '0, 3'd7, "R1");
        step(0, 0, '0, '0, 3'd0, "R1");
        step(0, 0, '0, '0, 3'd6, "R1");
        // R6: trigger and its read-back
        step(1, 3'd5, 32'h0000_0005, '0, 3'd7, "R6");
        step(0, 0, '0, '0, 3'd7, "R6");
        step(0, 0, '0, '0, 3'd5, "R6");
        step(0, 0, '0, '0, 3'd6, "R11");
        // R3: enable bit 0
        step(1, 3'd2, 32'h0000_0001, '0, 3'd0, "R3");
        step(0, 0, '0, '0, 3'd0, "R3");
        step(0, 0, '0, '0, 3'd6, "R9");
        step(0, 0, '0, '0, 3'd6, "R10");
        // R2: zeros do nothing, ones set
        step(1, 3'd1, '0, '0, 3'd0, "R2");
        step(0, 0, '0, '0, 3'd0, "R2");
        step(1, 3'd1, 32'h0000_0001, '0, 3'd0, "R2");
        step(0, 0, '0, '0, 3'd0, "R2");
        step(0, 0, '0, '0, 3'd7, "R11");
        step(1, 3'd2, 32'h0000_0005, '0, 3'd6, "R11");
        step(0, 0, '0, '0, 3'd6, "R11");
        step(0, 0, '0, '0, 3'd6, "R10");
        // R4 / R5: write-one-to-clear
        step(1, 3'd3, 32'h0000_0001, '0, 3'd7, "R4");
        step(1, 3'd3, '0, '0, 3'd7, "R4");
        step(0, 0, '0, '0, 3'd7, "R4");
        step(1, 3'd4, 32'h0000_0004, '0, 3'd7, "R5");
        step(0, 0, '0, '0, 3'd7, "R5");
        step(0, 0, '0, '0, 3'd6, "R10");
        // R7: hardware event
        step(0, 0, '0, 32'h0000_0010, 3'd7, "R7");
        step(0, 0, '0, '0, 3'd7, "R7");
        // R8: raise beats clear in the same cycle
        step(1, 3'd3, 32'h0000_0010, 32'h0000_0010, 3'd7, "R8");
        step(0, 0, '0, '0, 3'd7, "R8");
        step(1, 3'd4, 32'h0000_0030, 32'h0000_0020, 3'd7, "R8");
        step(0, 0, '0, '0, 3'd7, "R8");
        step(1, 3'd5, 32'h8000_0000, '0, 3'd7, "R8");
        step(1, 3'd4, 32'h8000_0000, 32'h8000_0000, 3'd7, "R8");
        step(0, 0, '0, '0, 3'd7, "R8");
        // R12: read-only indices ignore writes
        step(1, 3'd0, '0, '0, 3'd0, "R12");
        step(1, 3'd7, '1, '0, 3'd0, "R12");
        step(1, 3'd6, '1, '0, 3'd7, "R12");
        step(0, 0, '0, '0, 3'd7, "R12");
        step(0, 0, '0, '0, 3'd0, "R12");
        // R9: random traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [N-1:0] ev;
            ev = (($urandom % 4) == 0) ? (32'h1 << ($urandom % N)) : '0;
            step(($urandom % 2) == 0, 3'($urandom % 8), $urandom & $urandom, ev,
                 3'($urandom % 8), "R9");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule